// File: doc/BRIEF.md
# Two-Word Road Packet Link

This block moves pattern-match road records over an 18-bit parallel link. A record is made of a 20-bit pattern address, a 3-bit pipeline index (one of 8 pipelines), a 2-bit board-slot index (one of 4 sub-boards), an 8-bit hit bitmap and two flags, end-of-event and end-of-packet. The transmitter joins the pipeline index, slot index and pattern address into a 25-bit road address. It then sends the record as two consecutive link words. The write-enable travels only in the first word, and the two end flags travel only in the second.

The receiver watches the link. It treats any word with write-enable set as the start of a record and takes the word after it as the record's tail. It rebuilds the fields and offers them on a valid/ready output. The output holds one completed record. One more completed record can wait in a side register while the output is stalled. A start word that arrives while that side register is still occupied is dropped, and a one-cycle framing-error pulse is raised.

Transmitter states: `TX_IDLE` (ready; drives a zero word, or the first word when a record is accepted, then goes to `TX_TAIL`) and `TX_TAIL` (drives the second word, then always returns to `TX_IDLE`). Receiver states: `RX_HUNT` (waits for a start word, then goes to `RX_TAIL`), `RX_TAIL` (takes the tail word; goes to `RX_HUNT` if the output is free, otherwise to `RX_PARKED`) and `RX_PARKED` (holds the rebuilt record until the output frees). When the output frees, `RX_PARKED` goes to `RX_TAIL` if a start word arrives in that same cycle, and to `RX_HUNT` otherwise.

Top module: `road_link`

## Requirements
- R1: The road address is {pipeline[2:0], slot[1:0], pattern[19:0]} (bit 24 down to 0). The first link word has bit 17 = 1 (write-enable) and bits 16:0 = road address bits 24:8.
- R2: The second link word has bit 17 = end-of-event, bit 16 = end-of-packet, bits 15:8 = bitmap and bits 7:0 = road address bits 7:0.
- R3: The first word appears on `link_out` in the cycle after a record is accepted (`in_valid` and `in_ready` high at a clock edge). The second word appears in the cycle after that. `in_ready` is low while the second word is being sent, so at most one record is accepted every two cycles, and back-to-back records follow with no gap.
- R4: When no record is being sent, `link_out` is all zero.
- R5: `out_valid` rises in the cycle after the second word is present on `link_in`, provided the output is free. The rebuilt pipeline, slot, pattern, bitmap and flags then equal the transmitted record. The output drops after one cycle when `out_ready` is high.
- R6: While the receiver waits for a start, words with bit 17 = 0 (idle or otherwise) produce no record and no framing error.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields stay unchanged.
- R8: A record completed while the output is stalled is kept. It is delivered after the stalled record, in arrival order, with no loss.
- R9: A word with bit 17 = 1 that arrives while a completed record is parked behind a stalled output raises `frame_err` for exactly one cycle. That word is discarded, and both held records are still delivered.
- R10: After reset, `in_ready` = 1, `link_out` = 0, `out_valid` = 0 and `frame_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transmit record offered |
| in_ready | output | 1 | Transmitter can take a record |
| in_pipe | input | 3 | Pipeline index |
| in_slot | input | 2 | Board-slot index |
| in_pattern | input | 20 | Pattern address |
| in_bitmap | input | 8 | Hit bitmap |
| in_eoe | input | 1 | End-of-event flag |
| in_eop | input | 1 | End-of-packet flag |
| link_out | output | 18 | Transmitted link word |
| link_in | input | 18 | Received link word |
| out_valid | output | 1 | Rebuilt record available |
| out_ready | input | 1 | Consumer takes the record |
| out_pipe | output | 3 | Rebuilt pipeline index |
| out_slot | output | 2 | Rebuilt board-slot index |
| out_pattern | output | 20 | Rebuilt pattern address |
| out_bitmap | output | 8 | Rebuilt hit bitmap |
| out_eoe | output | 1 | Rebuilt end-of-event flag |
| out_eop | output | 1 | Rebuilt end-of-packet flag |
| frame_err | output | 1 | One-cycle pulse on a discarded start word |

## Verification
The hardest case to reach is the framing error. It needs a record stalled at the output, a second complete record parked behind it, and a start word arriving before either drains. The bench holds `out_ready` low and sends two records through the looped-back transmitter so that the second one parks. It then overrides `link_in` for one cycle with a bare start word, checks the error pulse, and releases the output to confirm that only the two real records emerge, in order. The same override is used to feed non-start words to an idle receiver.

// File: rtl/road_link_pkg.sv
package road_link_pkg;

    localparam int LINK_W = 18;
    localparam int PAT_W  = 20;
    localparam int PIPE_W = 3;
    localparam int SLOT_W = 2;
    localparam int MAP_W  = 8;
    localparam int ROAD_W = PIPE_W + SLOT_W + PAT_W;
    localparam int HEAD_W = LINK_W - 1;
    localparam int TAIL_W = ROAD_W - HEAD_W;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
        logic [SLOT_W-1:0] slot;
        logic [PAT_W-1:0]  pattern;
        logic [MAP_W-1:0]  bitmap;
        logic              eoe;
        logic              eop;
    } road_rec_t;

    function automatic logic [ROAD_W-1:0] road_addr(input road_rec_t r);
        return {r.pipe, r.slot, r.pattern};
    endfunction

    // start word: write-enable on top, upper road bits below it
    function automatic logic [LINK_W-1:0] head_word(input road_rec_t r);
        logic [ROAD_W-1:0] a;
        a = road_addr(r);
        return {1'b1, a[ROAD_W-1:TAIL_W]};
    endfunction

    // tail word: flags on top, then bitmap, then low road bits
    function automatic logic [LINK_W-1:0] tail_word(input road_rec_t r);
        logic [ROAD_W-1:0] a;
        a = road_addr(r);
        return {r.eoe, r.eop, r.bitmap, a[TAIL_W-1:0]};
    endfunction

    function automatic road_rec_t rebuild(input logic [HEAD_W-1:0] head,
                                          input logic [LINK_W-1:0] tail);
        logic [ROAD_W-1:0] a;
        road_rec_t         r;
        a         = {head, tail[TAIL_W-1:0]};
        r.pipe    = a[ROAD_W-1 -: PIPE_W];
        r.slot    = a[PAT_W+SLOT_W-1 -: SLOT_W];
        r.pattern = a[PAT_W-1:0];
        r.bitmap  = tail[TAIL_W +: MAP_W];
        r.eop     = tail[LINK_W-2];
        r.eoe     = tail[LINK_W-1];
        return r;
    endfunction

endpackage

// File: rtl/road_link_tx.sv
module road_link_tx
    import road_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  road_rec_t         rec,
    output logic [LINK_W-1:0] link_word
);

    typedef enum logic [0:0] {TX_IDLE, TX_TAIL} tx_state_t;

    tx_state_t         state_q, state_d;
    logic [LINK_W-1:0] tail_q;
    logic [LINK_W-1:0] word_q;
    logic              take;

    assign rec_ready = (state_q == TX_IDLE);
    assign take      = rec_valid && rec_ready;
    assign link_word = word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (take) state_d = TX_TAIL;
            TX_TAIL: state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            tail_q <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (take) begin
                        word_q <= head_word(rec);
                        tail_q <= tail_word(rec);
                    end else begin
                        word_q <= '0;
                    end
                end
                TX_TAIL: word_q <= tail_q;
                default: word_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/road_link_rx.sv
module road_link_rx
    import road_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] link_word,
    output logic              rec_valid,
    input  logic              rec_ready,
    output road_rec_t         rec,
    output logic              frame_err
);

    typedef enum logic [1:0] {RX_HUNT, RX_TAIL, RX_PARKED} rx_state_t;

    rx_state_t         state_q, state_d;
    logic [HEAD_W-1:0] head_q;
    road_rec_t         park_q;
    road_rec_t         out_q;
    logic              valid_q;
    logic              err_q;
    logic              is_start;
    logic              slot_free;
    road_rec_t         joined;

    assign is_start  = link_word[LINK_W-1];
    assign slot_free = !valid_q || rec_ready;
    assign joined    = rebuild(head_q, link_word);

    assign rec_valid = valid_q;
    assign rec       = out_q;
    assign frame_err = err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT:   if (is_start) state_d = RX_TAIL;
            RX_TAIL:   state_d = slot_free ? RX_HUNT : RX_PARKED;
            RX_PARKED: if (slot_free) state_d = is_start ? RX_TAIL : RX_HUNT;
            default:   state_d = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            park_q  <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (rec_ready) valid_q <= 1'b0;
            unique case (state_q)
                RX_HUNT: begin
                    if (is_start) head_q <= link_word[HEAD_W-1:0];
                end
                RX_TAIL: begin
                    if (slot_free) begin
                        out_q   <= joined;
                        valid_q <= 1'b1;
                    end else begin
                        park_q  <= joined;
                    end
                end
                RX_PARKED: begin
                    if (slot_free) begin
                        out_q   <= park_q;
                        valid_q <= 1'b1;
                        if (is_start) head_q <= link_word[HEAD_W-1:0];
                    end else if (is_start) begin
                        err_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/road_link.sv
module road_link
    import road_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIPE_W-1:0] in_pipe,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [PAT_W-1:0]  in_pattern,
    input  logic [MAP_W-1:0]  in_bitmap,
    input  logic              in_eoe,
    input  logic              in_eop,
    output logic [LINK_W-1:0] link_out,
    input  logic [LINK_W-1:0] link_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIPE_W-1:0] out_pipe,
    output logic [SLOT_W-1:0] out_slot,
    output logic [PAT_W-1:0]  out_pattern,
    output logic [MAP_W-1:0]  out_bitmap,
    output logic              out_eoe,
    output logic              out_eop,
    output logic              frame_err
);

    road_rec_t tx_rec;
    road_rec_t rx_rec;

    assign tx_rec.pipe    = in_pipe;
    assign tx_rec.slot    = in_slot;
    assign tx_rec.pattern = in_pattern;
    assign tx_rec.bitmap  = in_bitmap;
    assign tx_rec.eoe     = in_eoe;
    assign tx_rec.eop     = in_eop;

    road_link_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (in_valid),
        .rec_ready (in_ready),
        .rec       (tx_rec),
        .link_word (link_out)
    );

    road_link_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_word (link_in),
        .rec_valid (out_valid),
        .rec_ready (out_ready),
        .rec       (rx_rec),
        .frame_err (frame_err)
    );

    assign out_pipe    = rx_rec.pipe;
    assign out_slot    = rx_rec.slot;
    assign out_pattern = rx_rec.pattern;
    assign out_bitmap  = rx_rec.bitmap;
    assign out_eoe     = rx_rec.eoe;
    assign out_eop     = rx_rec.eop;

endmodule

// File: rtl/road_link_chk.sv
module road_link_chk
    import road_link_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PIPE_W-1:0] in_pipe,
    input logic [SLOT_W-1:0] in_slot,
    input logic [PAT_W-1:0]  in_pattern,
    input logic [MAP_W-1:0]  in_bitmap,
    input logic              in_eoe,
    input logic              in_eop,
    input logic [LINK_W-1:0] link_out,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PIPE_W-1:0] out_pipe,
    input logic [SLOT_W-1:0] out_slot,
    input logic [PAT_W-1:0]  out_pattern,
    input logic [MAP_W-1:0]  out_bitmap,
    input logic              out_eoe,
    input logic              out_eop,
    input logic              frame_err
);

    logic                    take;
    logic [PAT_W-TAIL_W-1:0] pat_hi;
    logic [TAIL_W-1:0]       pat_lo;

    assign take   = in_valid && in_ready;
    assign pat_hi = in_pattern[PAT_W-1:TAIL_W];
    assign pat_lo = in_pattern[TAIL_W-1:0];

    a_r1_head_word: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (link_out == {1'b1, $past(in_pipe), $past(in_slot), $past(pat_hi)}));

    a_r2_tail_word: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ##1 (link_out == {$past(in_eoe, 2), $past(in_eop, 2),
                                   $past(in_bitmap, 2), $past(pat_lo, 2)}));

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_ready);

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (link_out == '0));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pipe) && $stable(out_slot)
            && $stable(out_pattern) && $stable(out_bitmap)
            && $stable(out_eoe) && $stable(out_eop)));

    a_r9_err_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(out_valid && !out_ready));

    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

endmodule

bind road_link road_link_chk u_chk (.*);

// File: tb/road_link_bench.sv
module road_link_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_pipe;
    logic [1:0]  in_slot;
    logic [19:0] in_pattern;
    logic [7:0]  in_bitmap;
    logic        in_eoe;
    logic        in_eop;
    logic [17:0] link_out;
    logic [17:0] link_in;
    logic        out_valid;
    logic        out_ready;
    logic [2:0]  out_pipe;
    logic [1:0]  out_slot;
    logic [19:0] out_pattern;
    logic [7:0]  out_bitmap;
    logic        out_eoe;
    logic        out_eop;
    logic        frame_err;

    logic        inject;
    logic [17:0] inj_word;

    int          n_checks = 0;
    int          n_err    = 0;
    int          n_pop    = 0;
    int          n_ferr   = 0;
    logic [34:0] exp_q[$];
    logic [34:0] mon_exp;
    logic [34:0] outrec;

    always #5 clk = ~clk;

    assign link_in = inject ? inj_word : link_out;
    assign outrec  = {out_pipe, out_slot, out_pattern, out_bitmap, out_eoe, out_eop};

    road_link u_road_link (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // record layout: {pipe[34:32], slot[31:30], pattern[29:10], bitmap[9:2], eoe, eop}
    function automatic logic [34:0] mk(input int seed, input int i);
        logic [34:0] r;
        r[34:32] = 3'(seed + i);
        r[31:30] = 2'(seed * 3 + i);
        r[29:10] = 20'(seed * 40503 + i * 4660 + 17);
        r[9:2]   = 8'hA5 ^ 8'(i * 7);
        r[1]     = 1'(i);
        r[0]     = ~1'(i);
        return r;
    endfunction

    function automatic logic [17:0] w_first(input logic [34:0] r);
        return {1'b1, r[34:32], r[31:30], r[29:18]};
    endfunction

    function automatic logic [17:0] w_second(input logic [34:0] r);
        return {r[1], r[0], r[9:2], r[17:10]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_rec(input logic [34:0] r);
        chk(in_ready == 1'b1, "R3 ready when idle", in_ready, 1);
        in_valid   = 1'b1;
        in_pipe    = r[34:32];
        in_slot    = r[31:30];
        in_pattern = r[29:10];
        in_bitmap  = r[9:2];
        in_eoe     = r[1];
        in_eop     = r[0];
    endtask

    // sends n records back to back and checks every link word
    task automatic burst(input int seed, input int n);
        tick();
        drive_rec(mk(seed, 0));
        for (int i = 0; i < n; i++) begin
            tick();
            in_valid = 1'b0;
            @(negedge clk);
            chk(link_out == w_first(mk(seed, i)), "R1 first word", link_out, w_first(mk(seed, i)));
            chk(in_ready == 1'b0, "R3 ready low during tail", in_ready, 0);
            exp_q.push_back(mk(seed, i));
            tick();
            if (i + 1 < n) drive_rec(mk(seed, i + 1));
            @(negedge clk);
            chk(link_out == w_second(mk(seed, i)), "R2 second word", link_out, w_second(mk(seed, i)));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected record", 64'(outrec), 0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(outrec == mon_exp, "R5 rebuilt fields", 64'(outrec), 64'(mon_exp));
                n_pop++;
            end
        end
        if (rst_n && frame_err) n_ferr++;
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
        chk(link_out == '0, "R10 link_out after reset", link_out, 0);
        chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        chk(frame_err == 1'b0, "R10 frame_err after reset", frame_err, 0);
    endtask

    task automatic t_single();
        int p0;
        p0 = n_pop;
        burst(1, 1);
        chk(out_valid == 1'b0, "R5 not valid before tail sampled", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R5 valid after tail", out_valid, 1);
        chk(link_out == '0, "R4 idle after record", link_out, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 single-cycle valid", out_valid, 0);
        chk(n_pop == p0 + 1, "R5 one record delivered", n_pop, p0 + 1);
    endtask

    task automatic t_back_to_back();
        int p0;
        p0 = n_pop;
        burst(7, 5);
        @(negedge clk);
        chk(link_out == '0, "R4 idle after burst", link_out, 0);
        repeat (4) tick();
        chk(exp_q.size() == 0, "R3 burst drained", exp_q.size(), 0);
        chk(n_pop == p0 + 5, "R3 burst count", n_pop, p0 + 5);
    endtask

    task automatic t_garbage();
        int f0;
        f0 = n_ferr;
        inject = 1'b1;
        for (int k = 0; k < 6; k++) begin
            inj_word = {1'b0, 17'(k * 9157 + 3)};
            tick();
            @(negedge clk);
            chk(out_valid == 1'b0, "R6 non-start word ignored", out_valid, 0);
        end
        inject = 1'b0;
        chk(n_ferr == f0, "R6 no error on non-start", n_ferr, f0);
        burst(11, 1);
        repeat (3) tick();
        chk(exp_q.size() == 0, "R6 record after garbage", exp_q.size(), 0);
    endtask

    task automatic t_stall();
        logic [34:0] held;
        int p0, f0;
        p0 = n_pop;
        f0 = n_ferr;
        tick();
        out_ready = 1'b0;
        burst(21, 1);
        repeat (2) tick();
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 stalled valid", out_valid, 1);
        held = outrec;
        chk(held == mk(21, 0), "R5 stalled record fields", 64'(held), 64'(mk(21, 0)));
        burst(22, 1);
        for (int k = 0; k < 6; k++) begin
            tick();
            @(negedge clk);
            chk(out_valid && outrec == held, "R7 output held", 64'(outrec), 64'(held));
        end
        chk(n_ferr == f0, "R9 no error without extra start", n_ferr, f0);
        tick();
        out_ready = 1'b1;
        repeat (4) tick();
        chk(exp_q.size() == 0, "R8 both delivered", exp_q.size(), 0);
        chk(n_pop == p0 + 2, "R8 delivery count", n_pop, p0 + 2);
    endtask

    task automatic t_frame_err();
        int p0, f0;
        p0 = n_pop;
        f0 = n_ferr;
        tick();
        out_ready = 1'b0;
        burst(31, 1);
        burst(32, 1);
        repeat (3) tick();
        chk(frame_err == 1'b0, "R9 no error before start word", frame_err, 0);
        inject   = 1'b1;
        inj_word = 18'h20ABC;
        tick();
        inject   = 1'b0;
        @(negedge clk);
        chk(frame_err == 1'b1, "R9 error raised", frame_err, 1);
        tick();
        @(negedge clk);
        chk(frame_err == 1'b0, "R9 error is a pulse", frame_err, 0);
        chk(outrec == mk(31, 0), "R9 stalled record intact", 64'(outrec), 64'(mk(31, 0)));
        tick();
        out_ready = 1'b1;
        repeat (6) tick();
        chk(exp_q.size() == 0, "R9 held records delivered", exp_q.size(), 0);
        chk(n_pop == p0 + 2, "R9 start word discarded", n_pop, p0 + 2);
        chk(n_ferr == f0 + 1, "R9 one error cycle", n_ferr, f0 + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_pipe    = '0;
        in_slot    = '0;
        in_pattern = '0;
        in_bitmap  = '0;
        in_eoe     = 1'b0;
        in_eop     = 1'b0;
        out_ready  = 1'b1;
        inject     = 1'b0;
        inj_word   = '0;
        t_reset();
        t_single();
        t_back_to_back();
        t_garbage();
        t_stall();
        t_frame_err();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule